// File: doc/BRIEF.md
# Banked LCD Frame Memory with Row Scanner

This block keeps a monochrome frame of 68 rows by 102 columns, one bit per pixel, and shows it on a column bus one row at a time. A host fills the frame one byte at a time. Each byte covers one column of a bank, which is a horizontal strip of rows. The position is held in a write address counter. The counter has a column part and a bank part, and the host loads each part separately. After every accepted byte the counter moves on by itself, so a run of bytes fills a whole strip without reloading the address.

The frame is cut into uneven strips. Eight full strips hold eight rows each. One short strip holds three rows. One final strip holds a single row of icon bits. A byte written to a short strip gives up its unused bits.

Independently of the host, a scanner steps through the rows whenever it sees a scan tick. It presents each row on the 102-bit column bus and marks the start of every frame with a strobe. A two-bit display mode reshapes the bus on its way out: blank, all on, normal or inverse. The mode never alters the stored frame.

Top module: `lcdram_ctrl`

## Requirements
- R1: After reset: `scan_row` is 67, `col_out` is all zero, `frame_start` is low, the display mode is blank, the frame is cleared, and the write address is column 0, bank 0.
- R2: An accepted write to bank b (0 to 7) at column x stores `din[k]` into row 8*b+k, column x, for k in 0..7.
- R3: A write to bank 8 stores `din[2:0]` into rows 64..66 at the addressed column. `din[7:3]` is dropped, and the icon row is left unchanged.
- R4: A write to bank 9 stores `din[0]` into row 67 at the addressed column. `din[7:1]` is dropped.
- R5: After every accepted write the column advances by one. Column 101 wraps to 0 and moves the bank up by one. Bank 9 wraps to bank 0.
- R6: A write while the column is above 101 or the bank is above 9 is ignored. The frame is not changed and the write address is not changed.
- R7: `set_x` loads the column from `din[6:0]` and `set_y` loads the bank from `din[3:0]`. Each leaves the other part unchanged. When `wr_data` is high in the same cycle, both loads are dropped.
- R8: `ctrl_wr` loads the mode from `din[1:0]`, with bit 1 as the first mode bit and bit 0 as the second. The codes are: 00 makes `col_out` all zero, 01 makes it all one, 10 shows the row as stored, and 11 shows it inverted. The new mode is visible on `col_out` in the cycle after the load. The frame itself is not changed.
- R9: Each `scan_tick` moves `scan_row` to the next row, and row 67 is followed by row 0. At the same moment the tick latches that row so that `col_out[n]` reflects column n. Without a tick, the row and the latched data stay where they are.
- R10: `frame_start` is high for exactly the cycle after a tick that lands on row 0, and is low at all other times.
- R11: Host writes never delay a scan tick. If a tick loads a row in the same cycle that a write changes it, the loaded row holds the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_x | input | 1 | Load column address from din |
| set_y | input | 1 | Load bank address from din |
| wr_data | input | 1 | Write din at the current address |
| ctrl_wr | input | 1 | Load display mode from din[1:0] |
| din | input | 8 | Command or pixel byte |
| scan_tick | input | 1 | Advance the scanner by one row |
| scan_row | output | 7 | Row currently presented |
| col_out | output | 102 | Column bus after the display mode |
| frame_start | output | 1 | One-cycle strobe when row 0 is presented |

## Verification
The bench builds the block with its default values: 102 columns, eight full banks of eight rows, a three-row short bank and an 8-bit data byte. These are the sizes at which the uneven strip layout, the wrap from column 101 and the wrap from bank 9 all occur. Ticking every second cycle covers the whole frame in 136 cycles, so every row a phase has written gets scanned and compared before the next phase starts. Random traffic mixed with these ticks covers address values outside the valid range, and it also produces writes that land on a row in the same cycle that row is latched.

// File: rtl/lcdram_pkg.sv
package lcdram_pkg;

  // {first mode bit, second mode bit}
  typedef enum logic [1:0] {
    MODE_BLANK   = 2'b00,
    MODE_ALLON   = 2'b01,
    MODE_NORMAL  = 2'b10,
    MODE_INVERSE = 2'b11
  } disp_mode_e;

  // first row covered by a bank
  function automatic int bank_base(input int bank, input int lanes,
                                   input int full, input int part);
    if (bank <= full) return bank * lanes;
    return full * lanes + part;
  endfunction

  // number of rows a bank holds (0 for an unused bank code)
  function automatic int bank_rows(input int bank, input int lanes,
                                   input int full, input int part);
    if (bank < full) return lanes;
    if (bank == full) return part;
    if (bank == full + 1) return 1;
    return 0;
  endfunction

endpackage

// File: rtl/lcdram_addr.sv
module lcdram_addr #(
  parameter int COLS  = 102,
  parameter int BANKS = 10,
  parameter int XW    = 7,
  parameter int YW    = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_x_i,
  input  logic          set_y_i,
  input  logic          wr_i,
  input  logic [DW-1:0] din_i,
  output logic [XW-1:0] x_o,
  output logic [YW-1:0] y_o,
  output logic          wr_ok_o
);
  localparam logic [XW-1:0] XLAST = XW'(COLS - 1);
  localparam logic [YW-1:0] YLAST = YW'(BANKS - 1);

  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;

  wire x_valid  = (x_q <= XLAST);
  wire y_valid  = (y_q <= YLAST);
  wire wr_ok    = wr_i && x_valid && y_valid;
  wire col_wrap = wr_ok && (x_q == XLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (wr_ok) begin
      if (col_wrap) begin
        x_q <= '0;
        y_q <= (y_q == YLAST) ? '0 : y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end else if (!wr_i) begin
      if (set_x_i) x_q <= din_i[XW-1:0];
      if (set_y_i) y_q <= din_i[YW-1:0];
    end
  end

  assign x_o     = x_q;
  assign y_o     = y_q;
  assign wr_ok_o = wr_ok;

  a_r5_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !col_wrap) |=> (x_q == $past(x_q) + 1'b1) && $stable(y_q));

  a_r5_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    col_wrap |=> (x_q == '0) &&
                 (y_q == (($past(y_q) == YLAST) ? '0 : $past(y_q) + 1'b1)));

  a_r6_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !wr_ok) |=> $stable(x_q) && $stable(y_q));

  a_r7_set_col: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && set_x_i) |=> x_q == $past(din_i[XW-1:0]));

  a_r7_set_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && set_y_i) |=> y_q == $past(din_i[YW-1:0]));

endmodule

// File: rtl/lcdram_store.sv
module lcdram_store
  import lcdram_pkg::*;
#(
  parameter int COLS = 102,
  parameter int ROWS = 68,
  parameter int FULL = 8,
  parameter int PART = 3,
  parameter int DW   = 8,
  parameter int XW   = 7,
  parameter int YW   = 4,
  parameter int RW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ok_i,
  input  logic [XW-1:0]   x_i,
  input  logic [YW-1:0]   y_i,
  input  logic [DW-1:0]   din_i,
  input  logic [RW-1:0]   rd_row_i,
  output logic [COLS-1:0] rd_data_o
);
  localparam logic [YW-1:0] PART_BANK = YW'(FULL);
  localparam logic [YW-1:0] ICON_BANK = YW'(FULL + 1);

  logic [COLS-1:0] mem [ROWS];

  // lanes of din that belong to rows of the addressed bank
  logic [DW-1:0] lane_en;
  always_comb begin
    for (int k = 0; k < DW; k++)
      lane_en[k] = (k < bank_rows(int'(y_i), DW, FULL, PART));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (wr_ok_i) begin
      for (int k = 0; k < DW; k++)
        if (lane_en[k])
          mem[RW'(bank_base(int'(y_i), DW, FULL, PART) + k)][x_i] <= din_i[k];
    end
  end

  assign rd_data_o = mem[rd_row_i];

  a_r3_icon_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok_i && y_i == PART_BANK) |=> $stable(mem[ROWS-1]));

  a_r4_icon_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok_i && y_i == ICON_BANK) |=> mem[ROWS-1][$past(x_i)] == $past(din_i[0]));

  a_r3_lane_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok_i && y_i == PART_BANK) |-> $countones(lane_en) == PART);

endmodule

// File: rtl/lcdram_scan.sv
module lcdram_scan
  import lcdram_pkg::*;
#(
  parameter int ROWS = 68,
  parameter int COLS = 102,
  parameter int RW   = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  disp_mode_e      mode_i,
  input  logic [COLS-1:0] rd_data_i,
  output logic [RW-1:0]   rd_row_o,
  output logic [RW-1:0]   row_o,
  output logic [COLS-1:0] cols_o,
  output logic            frame_o
);
  localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

  function automatic logic [COLS-1:0] shade(input logic [COLS-1:0] px,
                                            input disp_mode_e m);
    case (m)
      MODE_BLANK:   return '0;
      MODE_ALLON:   return '1;
      MODE_NORMAL:  return px;
      default:      return ~px;
    endcase
  endfunction

  logic [RW-1:0]   row_q;
  logic [COLS-1:0] raw_q;
  logic            frame_q;

  wire [RW-1:0] nxt_row    = (row_q == LAST) ? '0 : row_q + 1'b1;
  wire          frame_wrap = tick_i && (nxt_row == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= LAST;
      raw_q   <= '0;
      frame_q <= 1'b0;
    end else begin
      frame_q <= frame_wrap;
      if (tick_i) begin
        row_q <= nxt_row;
        raw_q <= rd_data_i;
      end
    end
  end

  assign rd_row_o = nxt_row;
  assign row_o    = row_q;
  assign cols_o   = shade(raw_q, mode_i);
  assign frame_o  = frame_q;

  a_r9_row_range: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= LAST);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(row_q) && $stable(raw_q));

  a_r10_frame_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q |-> row_q == '0);

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q |=> !frame_q);

endmodule

// File: rtl/lcdram_ctrl.sv
module lcdram_ctrl
  import lcdram_pkg::*;
#(
  parameter int COLS       = 102,
  parameter int FULL_BANKS = 8,
  parameter int PART_ROWS  = 3,
  parameter int DW         = 8,
  parameter int YW         = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             set_x,
  input  logic                             set_y,
  input  logic                             wr_data,
  input  logic                             ctrl_wr,
  input  logic [DW-1:0]                    din,
  input  logic                             scan_tick,
  output logic [$clog2(FULL_BANKS*DW+PART_ROWS+1)-1:0] scan_row,
  output logic [COLS-1:0]                  col_out,
  output logic                             frame_start
);
  localparam int ROWS  = FULL_BANKS * DW + PART_ROWS + 1;
  localparam int BANKS = FULL_BANKS + 2;
  localparam int XW    = $clog2(COLS);
  localparam int RW    = $clog2(ROWS);

  logic [XW-1:0]   wx;
  logic [YW-1:0]   wy;
  logic            wr_ok;
  logic [RW-1:0]   rd_row;
  logic [COLS-1:0] rd_data;
  disp_mode_e      mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_BLANK;
    else if (ctrl_wr) mode_q <= disp_mode_e'(din[1:0]);
  end

  lcdram_addr #(.COLS(COLS), .BANKS(BANKS), .XW(XW), .YW(YW), .DW(DW)) u_addr (
    .clk(clk), .rst_n(rst_n), .set_x_i(set_x), .set_y_i(set_y),
    .wr_i(wr_data), .din_i(din), .x_o(wx), .y_o(wy), .wr_ok_o(wr_ok)
  );

  lcdram_store #(.COLS(COLS), .ROWS(ROWS), .FULL(FULL_BANKS), .PART(PART_ROWS),
                 .DW(DW), .XW(XW), .YW(YW), .RW(RW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok_i(wr_ok), .x_i(wx), .y_i(wy),
    .din_i(din), .rd_row_i(rd_row), .rd_data_o(rd_data)
  );

  lcdram_scan #(.ROWS(ROWS), .COLS(COLS), .RW(RW)) u_scan (
    .clk(clk), .rst_n(rst_n), .tick_i(scan_tick), .mode_i(mode_q),
    .rd_data_i(rd_data), .rd_row_o(rd_row), .row_o(scan_row),
    .cols_o(col_out), .frame_o(frame_start)
  );

  a_r8_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> mode_q == disp_mode_e'($past(din[1:0])));

  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(mode_q));

endmodule

// File: tb/tb_lcdram_ctrl.sv
module tb_lcdram_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic set_x = 0, set_y = 0, wr_data = 0, ctrl_wr = 0, scan_tick = 0;
  logic [7:0] din = '0;
  logic [6:0] scan_row;
  logic [101:0] col_out;
  logic frame_start;

  always #4 clk = ~clk;

  lcdram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .set_x(set_x), .set_y(set_y),
    .wr_data(wr_data), .ctrl_wr(ctrl_wr), .din(din), .scan_tick(scan_tick),
    .scan_row(scan_row), .col_out(col_out), .frame_start(frame_start)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit cmp_on = 0, auto_tick = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [101:0] m_mem [68];
  logic [101:0] m_raw;
  int m_row, mx, my;
  bit m_frame;
  logic [1:0] m_mode;

  always @(posedge clk) begin
    int nr;
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = '0;
      m_raw = '0; m_row = 67; m_frame = 0; m_mode = 2'b00; mx = 0; my = 0;
    end else begin
      if (scan_tick) begin
        nr = (m_row == 67) ? 0 : m_row + 1;
        m_raw = m_mem[nr];
        m_frame = (nr == 0);
        m_row = nr;
      end else m_frame = 0;
      if (ctrl_wr) m_mode = din[1:0];
      if (wr_data) begin
        if (mx < 102 && my < 10) begin
          if (my < 8)       for (int k = 0; k < 8; k++) m_mem[my*8+k][mx] = din[k];
          else if (my == 8) for (int k = 0; k < 3; k++) m_mem[64+k][mx] = din[k];
          else              m_mem[67][mx] = din[0];
          mx++;
          if (mx == 102) begin mx = 0; my = (my == 9) ? 0 : my + 1; end
        end
      end else begin
        if (set_x) mx = int'(din[6:0]);
        if (set_y) my = int'(din[3:0]);
      end
    end
  end

  function automatic logic [101:0] expect_cols();
    case (m_mode)
      2'b00: return '0;
      2'b01: return '1;
      2'b10: return m_raw;
      default: return ~m_raw;
    endcase
  endfunction

  // compare and drive ticks away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      checks++;
      if (int'(scan_row) != m_row) begin
        fails++; $display("FAIL R9 scan_row=%0d expected %0d", scan_row, m_row);
      end
      checks++;
      if (frame_start !== m_frame) begin
        fails++; $display("FAIL R10 frame_start=%0b expected %0b", frame_start, m_frame);
      end
      checks++;
      if (col_out !== expect_cols()) begin
        fails++; $display("FAIL %s row %0d col_out=%h expected %h",
                          cur_req, m_row, col_out, expect_cols());
      end
    end
    scan_tick = auto_tick && (cyc % 2 == 0);
  end

  task automatic cmd(input logic sx, input logic sy, input logic wr,
                     input logic ct, input logic [7:0] d);
    @(negedge clk);
    set_x = sx; set_y = sy; wr_data = wr; ctrl_wr = ct; din = d;
    @(negedge clk);
    set_x = 0; set_y = 0; wr_data = 0; ctrl_wr = 0; din = '0;
  endtask

  task automatic sx(input int v); cmd(1, 0, 0, 0, 8'(v)); endtask
  task automatic sy(input int v); cmd(0, 1, 0, 0, 8'(v)); endtask
  task automatic wr(input int v); cmd(0, 0, 1, 0, 8'(v)); endtask
  task automatic mode(input int v); cmd(0, 0, 0, 1, 8'(v)); endtask
  task automatic run(input int n); repeat (n) @(negedge clk); endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (scan_row !== 7'd67 || col_out !== '0 || frame_start !== 1'b0) begin
      fails++; $display("FAIL R1 row=%0d cols=%h frame=%0b expected 67/0/0",
                        scan_row, col_out, frame_start);
    end
    cmp_on = 1; auto_tick = 1;
    run(140);                        // blank mode hides everything (R1, R8)

    cur_req = "R8"; mode(2);
    cur_req = "R7"; sx(5); sy(2); wr(8'hA5); wr(8'h3C); sx(90); wr(8'h81);
    run(150);

    cur_req = "R2";
    for (int b = 0; b < 8; b++) begin
      sy(b); sx(7*b + 3); wr(b*37 + 1); wr(8'hFF); wr(8'h5A);
    end
    run(150);

    cur_req = "R3"; sy(8); sx(0); wr(8'hFF); sx(50); wr(8'hFA); wr(8'h05);
    run(150);

    cur_req = "R4"; sy(9); sx(9); wr(8'hFE); wr(8'h01); wr(8'hFF);
    run(150);

    cur_req = "R5"; sy(9); sx(100); wr(8'h81); wr(8'h43); wr(8'h18);
    sy(3); sx(101); wr(8'h77); wr(8'h66);
    run(150);

    cur_req = "R6"; sy(5); sx(102); wr(8'hFF); wr(8'hFF); sx(127); wr(8'hFF);
    sx(0); sy(12); wr(8'hFF); sy(1); wr(8'h99);   // must land at column 0
    run(150);

    cur_req = "R11";
    for (int i = 0; i < 400; i++) begin
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick < 7)       wr(int'($urandom_range(0, 255)));
      else if (pick == 7) sx(int'($urandom_range(0, 110)));
      else                sy(int'($urandom_range(0, 11)));
    end
    run(150);

    cur_req = "R8";
    for (int m = 0; m < 4; m++) begin mode(m); run(140); end
    mode(2);

    cur_req = "R9"; auto_tick = 0; run(30); auto_tick = 1; run(150);

    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule